// File: doc/BRIEF.md
# Speculative Prefetch Buffer

This block sits next to a memory controller. When a last-level cache misses, the missing partition may start a speculative memory read before coherence has settled whether the line will come from another cache or from memory. The buffer allocates a slot for that address and issues the read. It keeps the returned line, together with the requester tag, until the demand memory read for the same address arrives. The demand read is then answered from the buffer, and memory is not read a second time.

A demand read can find its slot still waiting for memory. In that case the slot is marked claimed, and the line goes to the requester as soon as memory returns it. A demand read that finds no slot is passed to memory unchanged. If the line was supplied cache-to-cache instead, a cancel input withdraws the prefetch. Slots are matched on the full address. A prefetch finding no free slot takes over the oldest filled, unclaimed slot; if there is none, the prefetch is dropped.

Top module: `spec_pf_buffer`

## Requirements
- R1: After reset, every slot is empty and all outputs are low; a demand read for an address prefetched before the reset is forwarded to memory.
- R2: A prefetch for an address not held, with a free slot, takes the lowest-indexed free slot. On the next edge it drives `spec_rd_valid_o` with that address and with the slot index on `spec_rd_id_o`.
- R3: A prefetch whose address is already held by a live slot (waiting or filled) is ignored and issues no memory read.
- R4: A memory return on `ret_id_i` fills a waiting slot. A demand read that hits a filled, unclaimed slot is not forwarded. The edge after the demand is sampled, `rsp_valid_o` carries the stored tag and data, and the slot is then free.
- R5: A demand read that hits a waiting slot is not forwarded. The edge after the matching memory return, the response carries the returned data and the prefetch tag.
- R6: A demand read that hits no live slot is forwarded on the next edge on `fwd_valid_o`/`fwd_addr_o` with its address unchanged.
- R7: A prefetch arriving with no free slot replaces the filled, unclaimed slot allocated longest ago. That slot's index is issued as the new read id, and the old address is no longer held.
- R8: A prefetch arriving with no free slot and no filled, unclaimed slot is dropped: no read is issued and the address is not held.
- R9: A cancel for a filled slot frees it at once, so a later demand read for that address is forwarded.
- R10: A cancel for a waiting slot stops it from matching. Its later memory return frees it without a response, and a new prefetch for the same address takes a different slot.
- R11: A memory return whose slot is free or already filled changes nothing: no response appears and the stored data is kept.
- R12: At most one response leaves per cycle. When several claimed slots hold data, the lowest index goes first, one per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pf_valid_i | input | 1 | Speculative read request |
| pf_addr_i | input | ADDR_W | Line address of the request |
| pf_tag_i | input | TAG_W | Requester tag returned with the data |
| spec_rd_valid_o | output | 1 | Speculative memory read issued |
| spec_rd_addr_o | output | ADDR_W | Address of the speculative read |
| spec_rd_id_o | output | ID_W | Slot index to echo on return |
| ret_valid_i | input | 1 | Memory data return for a speculative read |
| ret_id_i | input | ID_W | Slot index of the return |
| ret_data_i | input | DATA_W | Returned line data |
| dm_valid_i | input | 1 | Demand memory read |
| dm_addr_i | input | ADDR_W | Demand read address |
| fwd_valid_o | output | 1 | Demand read passed through to memory |
| fwd_addr_o | output | ADDR_W | Passed-through address |
| cx_valid_i | input | 1 | Withdraw a prefetch |
| cx_addr_i | input | ADDR_W | Address to withdraw |
| rsp_valid_o | output | 1 | Data delivered to requester |
| rsp_tag_o | output | TAG_W | Requester tag of the delivered line |
| rsp_data_o | output | DATA_W | Delivered line data |

## Verification
The bench fills every slot and then forces replacement. A design with the wrong age order evicts a newer line, which shows up as the wrong read id or a missing forward. A design that ignores fullness writes over waiting slots instead of dropping the prefetch. It cancels a waiting slot and then sends a stale memory return. A design that frees the slot on cancel would hand the stale data to the next owner of that index, or would block the re-prefetch of the address. It sends stray returns to free and filled slots, which a careless design would turn into responses or overwritten data. It makes two claimed slots ready on the same edge to check that responses leave one at a time, lowest index first, with nothing lost.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_PEND  = 2'd1,
    SLOT_VALID = 2'd2
  } slot_state_e;
endpackage

// File: rtl/spf_first_set.sv
module spf_first_set #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/spf_oldest.sv
module spf_oldest #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int SW = 8
) (
  input  logic [N-1:0]         cand_i,
  input  logic [N-1:0][SW-1:0] stamp_i,
  input  logic [SW-1:0]        now_i,
  output logic                 found_o,
  output logic [IW-1:0]        idx_o
);
  logic [SW-1:0] best;
  logic [SW-1:0] age;

  // largest distance from the running stamp wins; ties keep the lower index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    age     = '0;
    for (int i = 0; i < N; i++) begin
      age = now_i - stamp_i[i];
      if (cand_i[i] && (!found_o || age > best)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        best    = age;
      end
    end
  end
endmodule

// File: rtl/spf_slot.sv
module spf_slot
  import spf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 8,
  parameter int STAMP_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic [ADDR_W-1:0]  alloc_addr_i,
  input  logic [TAG_W-1:0]   alloc_tag_i,
  input  logic [STAMP_W-1:0] alloc_stamp_i,
  input  logic               ret_i,
  input  logic [DATA_W-1:0]  ret_data_i,
  input  logic               cancel_i,
  input  logic               claim_i,
  input  logic               grant_i,
  input  logic [ADDR_W-1:0]  pf_addr_i,
  input  logic [ADDR_W-1:0]  dm_addr_i,
  input  logic [ADDR_W-1:0]  cx_addr_i,
  output logic               free_o,
  output logic               valid_o,
  output logic               claimed_o,
  output logic [TAG_W-1:0]   tag_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [STAMP_W-1:0] stamp_o,
  output logic               pf_hit_o,
  output logic               dm_hit_o,
  output logic               cx_hit_o
);
  slot_state_e        state_q;
  logic               orphan_q;
  logic               claimed_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [TAG_W-1:0]   tag_q;
  logic [DATA_W-1:0]  data_q;
  logic [STAMP_W-1:0] stamp_q;
  logic               live;

  assign live      = (state_q != SLOT_FREE) && !orphan_q;
  assign free_o    = (state_q == SLOT_FREE);
  assign valid_o   = (state_q == SLOT_VALID);
  assign claimed_o = claimed_q;
  assign tag_o     = tag_q;
  assign data_o    = data_q;
  assign stamp_o   = stamp_q;
  assign pf_hit_o  = live && (addr_q == pf_addr_i);
  assign dm_hit_o  = live && (addr_q == dm_addr_i);
  assign cx_hit_o  = live && (addr_q == cx_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SLOT_FREE;
      orphan_q  <= 1'b0;
      claimed_q <= 1'b0;
      addr_q    <= '0;
      tag_q     <= '0;
      data_q    <= '0;
      stamp_q   <= '0;
    end else if (alloc_i) begin
      state_q   <= SLOT_PEND;
      orphan_q  <= 1'b0;
      claimed_q <= 1'b0;
      addr_q    <= alloc_addr_i;
      tag_q     <= alloc_tag_i;
      stamp_q   <= alloc_stamp_i;
    end else if (ret_i && state_q == SLOT_PEND) begin
      if (orphan_q || cancel_i) begin
        // withdrawn read drains here, never delivered
        state_q   <= SLOT_FREE;
        orphan_q  <= 1'b0;
        claimed_q <= 1'b0;
      end else begin
        state_q   <= SLOT_VALID;
        data_q    <= ret_data_i;
        claimed_q <= claimed_q | claim_i;
      end
    end else if (grant_i) begin
      state_q   <= SLOT_FREE;
      claimed_q <= 1'b0;
    end else if (cancel_i) begin
      claimed_q <= 1'b0;
      if (state_q == SLOT_PEND) orphan_q <= 1'b1;
      else                      state_q  <= SLOT_FREE;
    end else if (claim_i) begin
      claimed_q <= 1'b1;
    end
  end

  // R10
  orphan_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orphan_q |-> state_q == SLOT_PEND);

  // R5
  fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && state_q == SLOT_PEND && !orphan_q && !cancel_i && !alloc_i)
      |=> state_q == SLOT_VALID);

  // R4
  grant_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> (state_q == SLOT_VALID && claimed_q));
endmodule

// File: rtl/spec_pf_buffer.sv
module spec_pf_buffer #(
  parameter int N_ENTRIES = 64,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int TAG_W     = 8,
  parameter int STAMP_W   = 16,
  localparam int ID_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pf_valid_i,
  input  logic [ADDR_W-1:0] pf_addr_i,
  input  logic [TAG_W-1:0]  pf_tag_i,
  output logic              spec_rd_valid_o,
  output logic [ADDR_W-1:0] spec_rd_addr_o,
  output logic [ID_W-1:0]   spec_rd_id_o,
  input  logic              ret_valid_i,
  input  logic [ID_W-1:0]   ret_id_i,
  input  logic [DATA_W-1:0] ret_data_i,
  input  logic              dm_valid_i,
  input  logic [ADDR_W-1:0] dm_addr_i,
  output logic              fwd_valid_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  input  logic              cx_valid_i,
  input  logic [ADDR_W-1:0] cx_addr_i,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int N = N_ENTRIES;

  logic [N-1:0] free_vec, valid_vec, claimed_vec;
  logic [N-1:0] pf_hit_vec, dm_hit_vec, cx_hit_vec;
  logic [N-1:0] cx_vec, claim_vec, cand_vec, ready_vec;
  logic [N-1:0] alloc_vec, ret_vec, grant_vec;
  logic [N-1:0][TAG_W-1:0]   slot_tag;
  logic [N-1:0][DATA_W-1:0]  slot_data;
  logic [N-1:0][STAMP_W-1:0] slot_stamp;

  logic [STAMP_W-1:0] stamp_q;
  logic               free_found, old_found, grant_found;
  logic [ID_W-1:0]    free_idx, old_idx, grant_idx, alloc_idx;
  logic               pf_ok, dm_fwd;

  assign cx_vec    = cx_valid_i ? cx_hit_vec : '0;
  // a claimed slot does not take a second demand; that one goes to memory
  assign claim_vec = dm_valid_i ? (dm_hit_vec & ~claimed_vec & ~cx_vec) : '0;
  assign dm_fwd    = dm_valid_i && (claim_vec == '0);
  assign cand_vec  = valid_vec & ~claimed_vec & ~claim_vec & ~cx_vec;
  assign ready_vec = valid_vec & claimed_vec;

  spf_first_set #(.N(N), .IW(ID_W)) u_free_pick (
    .req_i(free_vec), .found_o(free_found), .idx_o(free_idx));

  spf_oldest #(.N(N), .IW(ID_W), .SW(STAMP_W)) u_victim_pick (
    .cand_i(cand_vec), .stamp_i(slot_stamp), .now_i(stamp_q),
    .found_o(old_found), .idx_o(old_idx));

  spf_first_set #(.N(N), .IW(ID_W)) u_rsp_pick (
    .req_i(ready_vec), .found_o(grant_found), .idx_o(grant_idx));

  assign pf_ok     = pf_valid_i && (pf_hit_vec == '0) && (free_found || old_found);
  assign alloc_idx = free_found ? free_idx : old_idx;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      alloc_vec[i] = pf_ok && (alloc_idx == ID_W'(i));
      ret_vec[i]   = ret_valid_i && (ret_id_i == ID_W'(i));
      grant_vec[i] = grant_found && (grant_idx == ID_W'(i));
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    spf_slot #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .STAMP_W(STAMP_W)
    ) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (alloc_vec[g]),
      .alloc_addr_i (pf_addr_i),
      .alloc_tag_i  (pf_tag_i),
      .alloc_stamp_i(stamp_q),
      .ret_i        (ret_vec[g]),
      .ret_data_i   (ret_data_i),
      .cancel_i     (cx_vec[g]),
      .claim_i      (claim_vec[g]),
      .grant_i      (grant_vec[g]),
      .pf_addr_i    (pf_addr_i),
      .dm_addr_i    (dm_addr_i),
      .cx_addr_i    (cx_addr_i),
      .free_o       (free_vec[g]),
      .valid_o      (valid_vec[g]),
      .claimed_o    (claimed_vec[g]),
      .tag_o        (slot_tag[g]),
      .data_o       (slot_data[g]),
      .stamp_o      (slot_stamp[g]),
      .pf_hit_o     (pf_hit_vec[g]),
      .dm_hit_o     (dm_hit_vec[g]),
      .cx_hit_o     (cx_hit_vec[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_q         <= '0;
      spec_rd_valid_o <= 1'b0;
      spec_rd_addr_o  <= '0;
      spec_rd_id_o    <= '0;
      fwd_valid_o     <= 1'b0;
      fwd_addr_o      <= '0;
      rsp_valid_o     <= 1'b0;
      rsp_tag_o       <= '0;
      rsp_data_o      <= '0;
    end else begin
      if (pf_ok) stamp_q <= stamp_q + 1'b1;
      spec_rd_valid_o <= pf_ok;
      spec_rd_addr_o  <= pf_ok ? pf_addr_i : '0;
      spec_rd_id_o    <= pf_ok ? alloc_idx : '0;
      fwd_valid_o     <= dm_fwd;
      fwd_addr_o      <= dm_fwd ? dm_addr_i : '0;
      rsp_valid_o     <= grant_found;
      rsp_tag_o       <= grant_found ? slot_tag[grant_idx] : '0;
      rsp_data_o      <= grant_found ? slot_data[grant_idx] : '0;
    end
  end

  // R2
  spec_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_rd_valid_o |-> $past(pf_valid_i));

  // R6
  fwd_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> $past(dm_valid_i));

  // R3
  no_dup_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pf_hit_vec) && $onehot0(dm_hit_vec));

  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_i && !free_found && !old_found) |=> !spec_rd_valid_o);

  // R12
  rsp_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(ready_vec != '0));
endmodule

// File: tb/spec_pf_buffer_test.sv
`timescale 1ns/1ps
module spec_pf_buffer_test;
  localparam int N = 4, AW = 16, DW = 16, TW = 4, SW = 8, IW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pf_valid_i = 1'b0;
  logic [AW-1:0] pf_addr_i = '0;
  logic [TW-1:0] pf_tag_i = '0;
  logic          ret_valid_i = 1'b0;
  logic [IW-1:0] ret_id_i = '0;
  logic [DW-1:0] ret_data_i = '0;
  logic          dm_valid_i = 1'b0;
  logic [AW-1:0] dm_addr_i = '0;
  logic          cx_valid_i = 1'b0;
  logic [AW-1:0] cx_addr_i = '0;
  logic          spec_rd_valid_o, fwd_valid_o, rsp_valid_o;
  logic [AW-1:0] spec_rd_addr_o, fwd_addr_o;
  logic [IW-1:0] spec_rd_id_o;
  logic [TW-1:0] rsp_tag_o;
  logic [DW-1:0] rsp_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  spec_pf_buffer #(
    .N_ENTRIES(N), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .STAMP_W(SW)
  ) uut (.*);

  typedef struct packed {
    logic pf_v; logic [15:0] pf_a; logic [3:0] pf_t;
    logic rt_v; logic [1:0] rt_id; logic [15:0] rt_d;
    logic dm_v; logic [15:0] dm_a;
    logic cx_v; logic [15:0] cx_a;
    logic e_sp; logic [1:0] e_id; logic e_fw;
    logic e_rsp; logic [3:0] e_tag; logic [15:0] e_dat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1,16'h0100,4'd1, 1'b0,2'd0,16'h0, 1'b0,16'h0, 1'b0,16'h0, 1'b1,2'd0,1'b0, 1'b0,4'd0,16'h0},
    '{1'b1,16'h0200,4'd2, 1'b0,2'd0,16'h0, 1'b0,16'h0, 1'b0,16'h0, 1'b1,2'd1,1'b0, 1'b0,4'd0,16'h0},
    '{1'b1,16'h0100,4'd3, 1'b0,2'd0,16'h0, 1'b0,16'h0, 1'b0,16'h0, 1'b0,2'd0,1'b0, 1'b0,4'd0,16'h0},
    '{1'b0,16'h0,4'd0, 1'b1,2'd0,16'hAAAA, 1'b0,16'h0, 1'b0,16'h0, 1'b0,2'd0,1'b0, 1'b0,4'd0,16'h0},
    '{1'b0,16'h0,4'd0, 1'b0,2'd0,16'h0, 1'b1,16'h0100, 1'b0,16'h0, 1'b0,2'd0,1'b0, 1'b0,4'd0,16'h0},
    '{1'b0,16'h0,4'd0, 1'b0,2'd0,16'h0, 1'b0,16'h0, 1'b0,16'h0, 1'b0,2'd0,1'b0, 1'b1,4'd1,16'hAAAA},
    '{1'b0,16'h0,4'd0, 1'b0,2'd0,16'h0, 1'b1,16'h0200, 1'b0,16'h0, 1'b0,2'd0,1'b0, 1'b0,4'd0,16'h0},
    '{1'b0,16'h0,4'd0, 1'b0,2'd0,16'h0, 1'b1,16'h0300, 1'b0,16'h0, 1'b0,2'd0,1'b1, 1'b0,4'd0,16'h0},
    '{1'b0,16'h0,4'd0, 1'b1,2'd1,16'hBBBB, 1'b0,16'h0, 1'b0,16'h0, 1'b0,2'd0,1'b0, 1'b0,4'd0,16'h0},
    '{1'b0,16'h0,4'd0, 1'b0,2'd0,16'h0, 1'b0,16'h0, 1'b0,16'h0, 1'b0,2'd0,1'b0, 1'b1,4'd2,16'hBBBB},
    '{1'b0,16'h0,4'd0, 1'b0,2'd0,16'h0, 1'b1,16'h0100, 1'b0,16'h0, 1'b0,2'd0,1'b1, 1'b0,4'd0,16'h0}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic clear_in();
    pf_valid_i = 0; ret_valid_i = 0; dm_valid_i = 0; cx_valid_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
    clear_in();
  endtask

  task automatic do_reset();
    clear_in();
    rst_ni = 0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
  endtask

  task automatic pf(input logic [15:0] a, input logic [3:0] t);
    pf_valid_i = 1; pf_addr_i = a; pf_tag_i = t; step();
  endtask
  task automatic ret(input logic [1:0] id, input logic [15:0] d);
    ret_valid_i = 1; ret_id_i = id; ret_data_i = d; step();
  endtask
  task automatic dm(input logic [15:0] a);
    dm_valid_i = 1; dm_addr_i = a; step();
  endtask
  task automatic cx(input logic [15:0] a);
    cx_valid_i = 1; cx_addr_i = a; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 spec idle", spec_rd_valid_o, 0);
    chk("R1 fwd idle", fwd_valid_o, 0);
    chk("R1 rsp idle", rsp_valid_o, 0);

    // table walk: R2 R3 R4 R5 R6
    for (int r = 0; r < NV; r++) begin
      pf_valid_i = VEC[r].pf_v; pf_addr_i = VEC[r].pf_a; pf_tag_i = VEC[r].pf_t;
      ret_valid_i = VEC[r].rt_v; ret_id_i = VEC[r].rt_id; ret_data_i = VEC[r].rt_d;
      dm_valid_i = VEC[r].dm_v; dm_addr_i = VEC[r].dm_a;
      cx_valid_i = VEC[r].cx_v; cx_addr_i = VEC[r].cx_a;
      step();
      chk("R2 R3 spec valid", spec_rd_valid_o, VEC[r].e_sp);
      if (VEC[r].e_sp) begin
        chk("R2 spec id", spec_rd_id_o, VEC[r].e_id);
        chk("R2 spec addr", spec_rd_addr_o, VEC[r].pf_a);
      end
      chk("R6 fwd valid", fwd_valid_o, VEC[r].e_fw);
      if (VEC[r].e_fw) chk("R6 fwd addr", fwd_addr_o, VEC[r].dm_a);
      chk("R4 R5 rsp valid", rsp_valid_o, VEC[r].e_rsp);
      if (VEC[r].e_rsp) begin
        chk("R4 R5 rsp tag", rsp_tag_o, VEC[r].e_tag);
        chk("R4 R5 rsp data", rsp_data_o, VEC[r].e_dat);
      end
    end

    // R7 R8 replacement and drop
    do_reset();
    pf(16'h10, 1); chk("R2 id0", spec_rd_id_o, 0);
    pf(16'h20, 2); chk("R2 id1", spec_rd_id_o, 1);
    pf(16'h30, 3); chk("R2 id2", spec_rd_id_o, 2);
    pf(16'h40, 4); chk("R2 id3", spec_rd_id_o, 3);
    ret(2, 16'h3333);
    ret(1, 16'h2222);
    pf(16'h50, 5);
    chk("R7 replace valid", spec_rd_valid_o, 1);
    chk("R7 oldest victim id", spec_rd_id_o, 1);
    chk("R7 replace addr", spec_rd_addr_o, 16'h50);
    dm(16'h20); chk("R7 evicted addr forwarded", fwd_valid_o, 1);
    pf(16'h60, 6); chk("R7 next victim id", spec_rd_id_o, 2);
    pf(16'h70, 7); chk("R8 dropped", spec_rd_valid_o, 0);
    dm(16'h70); chk("R8 dropped addr not held", fwd_valid_o, 1);

    // R9 R10 cancel
    do_reset();
    pf(16'h10, 1);
    ret(0, 16'h1111);
    cx(16'h10);
    dm(16'h10); chk("R9 cancelled line forwarded", fwd_valid_o, 1);
    step(); chk("R9 no rsp", rsp_valid_o, 0);
    pf(16'h20, 2); chk("R2 reuse id0", spec_rd_id_o, 0);
    cx(16'h20);
    pf(16'h20, 3);
    chk("R10 re-prefetch issued", spec_rd_valid_o, 1);
    chk("R10 re-prefetch new slot", spec_rd_id_o, 1);
    ret(0, 16'hDEAD);
    step(); chk("R10 stale return silent", rsp_valid_o, 0);
    dm(16'h20); chk("R10 demand hits new slot", fwd_valid_o, 0);
    ret(1, 16'hBEEF);
    step();
    chk("R10 rsp valid", rsp_valid_o, 1);
    chk("R10 rsp data", rsp_data_o, 16'hBEEF);
    chk("R10 rsp tag", rsp_tag_o, 3);
    pf(16'h30, 4); chk("R10 drained slot reused", spec_rd_id_o, 0);

    // R11 stray returns
    do_reset();
    pf(16'h40, 1);
    ret(0, 16'h4444);
    ret(0, 16'h9999);
    ret(3, 16'h7777);
    step(); chk("R11 no rsp from stray", rsp_valid_o, 0);
    dm(16'h40); chk("R11 held", fwd_valid_o, 0);
    step();
    chk("R11 rsp valid", rsp_valid_o, 1);
    chk("R11 data kept", rsp_data_o, 16'h4444);
    pf(16'h50, 2); pf(16'h60, 3); pf(16'h70, 4);
    pf(16'h80, 5); chk("R11 slot3 still free", spec_rd_id_o, 3);
    dm(16'h80); chk("R11 pending demand held", fwd_valid_o, 0);
    step(); chk("R11 no early rsp", rsp_valid_o, 0);

    // R12 two ready on one edge
    do_reset();
    pf(16'h10, 1); pf(16'h20, 2);
    ret(0, 16'h0101);
    dm(16'h20);
    ret_valid_i = 1; ret_id_i = 1; ret_data_i = 16'h0202;
    dm_valid_i = 1; dm_addr_i = 16'h10;
    step(); chk("R12 none yet", rsp_valid_o, 0);
    step();
    chk("R12 first valid", rsp_valid_o, 1);
    chk("R12 lowest first tag", rsp_tag_o, 1);
    chk("R12 lowest first data", rsp_data_o, 16'h0101);
    step();
    chk("R12 second valid", rsp_valid_o, 1);
    chk("R12 second data", rsp_data_o, 16'h0202);
    step(); chk("R12 done", rsp_valid_o, 0);

    // R1 reset in mid-run
    pf(16'h90, 1);
    ret(0, 16'h9090);
    do_reset();
    dm(16'h90); chk("R1 reset cleared", fwd_valid_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule